// File: doc/BRIEF.md
# CPU Address Decoder with Mirroring

This block sits between a small console CPU and its memory-mapped devices. It takes the 16-bit CPU address and the write enable and produces three things: a one-hot region select with the offset local to that region, side-band pulses for the I/O offsets that are not plain registers, and a filtered write enable for the storage behind the selected region. Work RAM appears four times in the lowest 8 KB and always reaches the same 2 KB, because the upper address bits are dropped from the RAM offset.

The I/O window holds three special offsets. A write to the DMA offset starts a sprite page copy, and the written byte becomes the upper byte of the source page address. A read of either controller offset goes to that controller port. A write to the first controller offset is the controller latch strobe. Reads from unmapped space return 0x00. Writes to ROM or to unmapped space never reach storage. Two parameters pick the cartridge layout: whether battery RAM is fitted, and whether the program image is 16 KB or 32 KB. A 16 KB image is aligned to the top of the address space.

Top module: `cpu_addr_decode`

## Requirements
- R1: Addresses 0x0000–0x1FFF assert sel[0] (work RAM) with offset = addr[10:0], so all four 2 KB copies reach the same locations.
- R2: Addresses 0x2000–0x2007 assert sel[1] (video registers) with offset = addr[2:0]; 0x2008–0x3FFF are unmapped.
- R3: Addresses 0x4000–0x4017 assert sel[2] (audio/IO registers) with offset = addr[4:0]; 0x4018–0x5FFF are unmapped.
- R4: With HAS_BATT=1, addresses 0x6000 up to 0x6000+2^BATT_AW−1 assert sel[3] (battery RAM) with offset = addr[BATT_AW-1:0]. With HAS_BATT=0 that range is unmapped.
- R5: With ROM_KB=32, 0x8000–0xFFFF assert sel[4] (program ROM) with offset = addr[14:0]. With ROM_KB=16, 0xC000–0xFFFF assert sel[4] with offset = addr[13:0], and 0x8000–0xBFFF are unmapped.
- R6: For every address exactly one of sel[4:0] and unmapped is high. The offset is 0 when unmapped is high.
- R7: A write to 0x4014 raises dma_start and drives dma_page = {wdata, 8'h00}. Otherwise dma_start is low and dma_page is 0.
- R8: A read of 0x4016 raises pad1_rd, a read of 0x4017 raises pad2_rd, and a write to 0x4016 raises pad_strobe.
- R9: dma_start and pad_strobe are high only while wr_en is high. pad1_rd and pad2_rd are high only while wr_en is low. Every other address leaves all four low.
- R10: store_we equals wr_en for work RAM, video, audio/IO and battery RAM, and is 0 for ROM and unmapped addresses.
- R11: cpu_rdata equals dev_rdata when the address is mapped and wr_en is low. It is 0x00 for unmapped addresses and during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | CPU address |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| wdata | input | 8 | CPU write data |
| dev_rdata | input | 8 | Read data returned by the selected device |
| sel | output | 5 | One-hot region: [0] RAM, [1] video, [2] audio/IO, [3] battery, [4] ROM |
| unmapped | output | 1 | Address falls in no region |
| offset | output | 15 | Region-local offset, zero-extended |
| store_we | output | 1 | Write enable to the selected storage |
| cpu_rdata | output | 8 | Read data to CPU |
| dma_start | output | 1 | Sprite DMA start pulse |
| dma_page | output | 16 | DMA source page address |
| pad1_rd | output | 1 | Controller port 1 read |
| pad2_rd | output | 1 | Controller port 2 read |
| pad_strobe | output | 1 | Controller latch strobe |

## Verification
The decoder holds no state, so every wrong boundary, mirror fold or offset slice shows up at the ports in the same cycle the address is presented. It appears as a wrong select bit, a misplaced offset, a missing unmapped flag, or a side-band pulse on a neighbouring address. Sweeping all 65,536 addresses in both read and write direction, in both cartridge configurations, therefore exposes any such defect at once. The DMA page path is swept over all 256 data values.

// File: rtl/cpu_addr_decode.sv
module cpu_addr_decode #(
  parameter int HAS_BATT = 1,
  parameter int BATT_AW  = 13,
  parameter int ROM_KB   = 32
) (
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  input  logic [7:0]  dev_rdata,
  output logic [4:0]  sel,
  output logic        unmapped,
  output logic [14:0] offset,
  output logic        store_we,
  output logic [7:0]  cpu_rdata,
  output logic        dma_start,
  output logic [15:0] dma_page,
  output logic        pad1_rd,
  output logic        pad2_rd,
  output logic        pad_strobe
);
  localparam int ROM_AW    = (ROM_KB == 16) ? 14 : 15;
  localparam int ROM_BASE  = 65536 - (1 << ROM_AW);
  localparam int BATT_BASE = 24576;
  localparam int BATT_END  = BATT_BASE + (1 << BATT_AW);

  logic ram_hit, vid_hit, io_hit, batt_hit, rom_hit;
  logic [4:0] io_off;

  assign ram_hit = addr[15:13] == 3'b000;
  assign vid_hit = addr[15:3] == 13'h0400;
  assign io_hit  = (addr[15:5] == 11'h200) && (addr[4:0] < 5'h18);
  assign rom_hit = 32'(addr) >= ROM_BASE;

  generate
    if (HAS_BATT != 0) begin : g_batt
      assign batt_hit = (32'(addr) >= BATT_BASE) && (32'(addr) < BATT_END);
    end else begin : g_nobatt
      assign batt_hit = 1'b0;
    end
  endgenerate

  assign sel      = {rom_hit, batt_hit, io_hit, vid_hit, ram_hit};
  assign unmapped = ~|sel;
  assign io_off   = addr[4:0];

  always_comb begin
    offset = '0;
    unique case (1'b1)
      ram_hit:  offset = 15'(addr[10:0]);
      vid_hit:  offset = 15'(addr[2:0]);
      io_hit:   offset = 15'(io_off);
      batt_hit: offset = 15'(addr[BATT_AW-1:0]);
      rom_hit:  offset = 15'(addr[ROM_AW-1:0]);
      default:  offset = '0;
    endcase
  end

  assign store_we   = wr_en & (ram_hit | vid_hit | io_hit | batt_hit);
  assign cpu_rdata  = (!wr_en && !unmapped) ? dev_rdata : 8'h00;
  assign dma_start  = wr_en & io_hit & (io_off == 5'h14);
  assign dma_page   = dma_start ? {wdata, 8'h00} : 16'h0000;
  assign pad_strobe = wr_en & io_hit & (io_off == 5'h16);
  assign pad1_rd    = ~wr_en & io_hit & (io_off == 5'h16);
  assign pad2_rd    = ~wr_en & io_hit & (io_off == 5'h17);

  always_comb begin
    if (!$isunknown({addr, wr_en, wdata, dev_rdata})) begin
      p_one_region_r6: assert ($countones({sel, unmapped}) == 1);
      p_unmapped_off_r6: assert (!unmapped || offset == 15'd0);
      p_ram_fold_r1: assert (!sel[0] || offset[14:11] == 4'd0);
      p_dma_we_r9: assert (!dma_start || wr_en);
      p_strobe_we_r9: assert (!pad_strobe || wr_en);
      p_pad_rd_r9: assert (!(pad1_rd || pad2_rd) || !wr_en);
      p_side_io_r8: assert ($countones({dma_start, pad_strobe, pad1_rd, pad2_rd}) == 0 || sel[2]);
      p_dma_page_r7: assert (dma_start || dma_page == 16'h0000);
      p_rom_wr_r10: assert (!(sel[4] || unmapped) || !store_we);
      p_open_read_r11: assert (!unmapped || cpu_rdata == 8'h00);
    end
  end
endmodule

// File: tb/cpu_addr_decode_tb_top.sv
module cpu_addr_decode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0, dev_rdata = '0;

  logic [4:0]  sel_a, sel_b;
  logic        unm_a, unm_b, swe_a, swe_b, dma_a, dma_b;
  logic        p1_a, p1_b, p2_a, p2_b, stb_a, stb_b;
  logic [14:0] off_a, off_b;
  logic [7:0]  rd_a, rd_b;
  logic [15:0] pg_a, pg_b;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  cpu_addr_decode #(.HAS_BATT(1), .BATT_AW(13), .ROM_KB(32)) dut_i (
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .dev_rdata(dev_rdata),
    .sel(sel_a), .unmapped(unm_a), .offset(off_a), .store_we(swe_a),
    .cpu_rdata(rd_a), .dma_start(dma_a), .dma_page(pg_a),
    .pad1_rd(p1_a), .pad2_rd(p2_a), .pad_strobe(stb_a));

  cpu_addr_decode #(.HAS_BATT(0), .BATT_AW(13), .ROM_KB(16)) dut_b (
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .dev_rdata(dev_rdata),
    .sel(sel_b), .unmapped(unm_b), .offset(off_b), .store_we(swe_b),
    .cpu_rdata(rd_b), .dma_start(dma_b), .dma_page(pg_b),
    .pad1_rd(p1_b), .pad2_rd(p2_b), .pad_strobe(stb_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h we=%0d actual=%h expected=%h", tag, addr, wr_en, act, exp);
    end
  endtask

  task automatic model(input int a, input bit batt, input bit rom16,
                       output logic [4:0] s, output logic [14:0] o, output string tag);
    s = '0; o = '0; tag = "R6";
    if (a < 'h2000)                  begin s = 5'b00001; o = 15'(a % 2048); tag = "R1"; end
    else if (a < 'h2008)             begin s = 5'b00010; o = 15'(a - 'h2000); tag = "R2"; end
    else if (a >= 'h4000 && a < 'h4018) begin s = 5'b00100; o = 15'(a - 'h4000); tag = "R3"; end
    else if (batt && a >= 'h6000 && a < 'h8000) begin s = 5'b01000; o = 15'(a - 'h6000); tag = "R4"; end
    else if (!rom16 && a >= 'h8000) begin s = 5'b10000; o = 15'(a - 'h8000); tag = "R5"; end
    else if (rom16 && a >= 'hC000)  begin s = 5'b10000; o = 15'(a - 'hC000); tag = "R5"; end
    else if (a >= 'h2008 && a < 'h4000) tag = "R2";
    else if (a >= 'h4018 && a < 'h6000) tag = "R3";
    else if (a >= 'h6000 && a < 'h8000) tag = "R4";
    else tag = "R5";
  endtask

  task automatic check_one(input bit cfg_b);
    logic [4:0] es; logic [14:0] eo; string tag;
    logic [4:0] s; logic [14:0] o; logic u, swe, dma, p1, p2, stb;
    logic [7:0] rd; logic [15:0] pg; bit mapped;
    int a = int'(addr);
    model(a, !cfg_b, cfg_b, es, eo, tag);
    if (cfg_b) begin s=sel_b; o=off_b; u=unm_b; swe=swe_b; rd=rd_b; dma=dma_b; pg=pg_b; p1=p1_b; p2=p2_b; stb=stb_b; end
    else       begin s=sel_a; o=off_a; u=unm_a; swe=swe_a; rd=rd_a; dma=dma_a; pg=pg_a; p1=p1_a; p2=p2_a; stb=stb_a; end
    mapped = es != 0;
    chk(tag, 32'(s), 32'(es));
    chk(tag, 32'(o), 32'(eo));
    chk("R6", 32'(u), 32'(!mapped));
    chk("R10", 32'(swe), 32'(wr_en && mapped && es != 5'b10000));
    chk("R11", 32'(rd), 32'((!wr_en && mapped) ? dev_rdata : 8'h00));
    chk("R7", {pg, 15'd0, dma}, (wr_en && a == 'h4014) ? {wdata, 8'h00, 15'd0, 1'b1} : 32'd0);
    chk("R8", 32'(p1), 32'(!wr_en && a == 'h4016));
    chk("R8", 32'(p2), 32'(!wr_en && a == 'h4017));
    chk("R9", 32'(stb), 32'(wr_en && a == 'h4016));
  endtask

  initial begin
    #(CLK_PERIOD/2 + 1);
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < 65536; a++) begin
        addr = 16'(a); wr_en = w[0];
        wdata = 8'(a >> 8) ^ 8'(a) ^ 8'h3C;
        dev_rdata = 8'(a) ^ 8'h5A;
        #1;
        check_one(1'b0);
        check_one(1'b1);
      end
    end
    addr = 16'h4014; wr_en = 1'b1;
    for (int d = 0; d < 256; d++) begin
      wdata = 8'(d);
      #1;
      chk("R7", 32'(pg_a), 32'({8'(d), 8'h00}));
      chk("R7", 32'(dma_b), 32'd1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule